// File: doc/BRIEF.md
# Bank-Interleaved SDRAM Read Sequencer

This block turns a stream of read requests into SDRAM commands for a four-bank device. Each request carries a bank, a row, a column and a small identifier. It is accepted through a valid/ready handshake. The request's row is opened with an activate command. The row is read and closed with a single read that carries the auto-precharge flag, so no separate precharge command is ever issued. While one bank's burst is still coming back, the activate for the next request can already go out, so row opening and precharge are hidden behind data transfer.

The sequencer enforces the device timing rules:
- the activate-to-read delay;
- the minimum row-open time;
- activate-to-activate spacing;
- the limit of two activates in any row-cycle window;
- the wait after an auto-precharge read before its bank can be reopened.

Returned data is captured from the data bus after the CAS latency. It is presented as a burst of BL words with a valid strobe and the identifier of the request it belongs to. All timing values, the CAS latency and the burst length are parameters. `cmd_o`, `ba_o` and `addr_o` are combinational and take effect at the next rising clock edge.

Top module: `sdram_rd_seq`

## Requirements
- R1: `req_ready_o` is high exactly when every activate rule below allows a new activate to bank `req_bank_i` and no activated request is still waiting for its read. On `req_valid_i && req_ready_o` the same cycle drives an activate: `cmd_o` = 1, `ba_o` = the request bank, `addr_o` = the request row.
- R2: A read with auto-precharge (`cmd_o` = 2) goes to the waiting bank in the first cycle that meets two conditions. At least max(T_RCD, T_RAS-BL) cycles have passed since that bank's activate, and R6 allows it. `addr_o` carries the column in its low COL_W bits and has bit 10 set.
- R3: Two activates are never closer than T_RRD cycles.
- R4: An activate is issued only if the activate two before it lies at least T_RC cycles back, so no T_RC window holds more than two activates.
- R5: No activate goes to a bank earlier than BL+T_RP cycles after the auto-precharge read to that bank.
- R6: Two reads are never closer than BL cycles, so bursts never overlap on the data bus.
- R7: For a read issued in cycle t, `rd_valid_o` is high in cycles t+CL+1 through t+CL+BL. In each of those cycles `rd_data_o` equals the `dq_i` value of the previous cycle and `rd_id_o` equals the request's identifier.
- R8: Requests are read in acceptance order, and at most one activated request waits for its read. The next activate may be issued while the previous burst is still being returned.
- R9: In every cycle without an activate or read, `cmd_o` is 0 (NOP). During reset `cmd_o` is 0 and `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_bank_i | input | BW | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request start column |
| req_id_i | input | ID_W | Request identifier |
| cmd_o | output | 2 | Command: 0 NOP, 1 activate, 2 read with auto-precharge |
| ba_o | output | BW | Command bank |
| addr_o | output | ROW_W | Command address (row, or column with bit 10 set) |
| dq_i | input | DQ_W | Data bus from the device |
| rd_valid_o | output | 1 | Returned word valid |
| rd_data_o | output | DQ_W | Returned word |
| rd_id_o | output | ID_W | Identifier of the returned word's request |

## Verification
The command, its bank and address, and `req_ready_o` are due in the same cycle as the request that causes them. Returned words are due CL+1 cycles after their read and continue for BL cycles. The bench drives inputs on the falling edge and samples outputs one nanosecond later. Its behavioural scheduler predicts the command of each cycle. A ring of expected words, keyed by cycle number, is filled at each observed read, so every returned word is compared in exactly the cycle it is due. Independent spacing, bank-reuse and ordering checks run on the observed command stream.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RDA = 2'd2
  } cmd_e;
endpackage

// File: rtl/sdram_act_gov.sv
module sdram_act_gov #(
  parameter int NB      = 4,
  parameter int T_RRD   = 2,
  parameter int T_RC    = 9,
  parameter int T_RP    = 3,
  parameter int BL      = 4,
  parameter int CNT_MAX = 40,
  localparam int BW  = $clog2(NB),
  localparam int CW  = $clog2(CNT_MAX + 1),
  localparam int BCW = $clog2(BL + T_RP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic [BW-1:0] bank_i,
  input  logic [BW-1:0] rd_bank_i,
  output logic          act_ok_o
);
  logic [CW-1:0] since1_q, since2_q;
  logic [NB-1:0] bank_free;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
    return (x == CW'(CNT_MAX)) ? x : x + 1'b1;
  endfunction

  // ages of the last two activates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since1_q <= CW'(CNT_MAX);
      since2_q <= CW'(CNT_MAX);
    end else if (act_i) begin
      since2_q <= sat_inc(since1_q);
      since1_q <= CW'(1);
    end else begin
      since1_q <= sat_inc(since1_q);
      since2_q <= sat_inc(since2_q);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BCW-1:0] busy_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            busy_q <= '0;
      else if (rd_i && rd_bank_i == BW'(b))   busy_q <= BCW'(BL + T_RP - 1);
      else if (busy_q != '0)                  busy_q <= busy_q - 1'b1;
    end
    assign bank_free[b] = (busy_q == '0);
  end

  assign act_ok_o = (since1_q >= CW'(T_RRD)) && (since2_q >= CW'(T_RC)) && bank_free[bank_i];

  assert_rrd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !act_i);
  assert_bank_reuse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !(act_i && bank_i == $past(rd_bank_i)));
endmodule

// File: rtl/sdram_rd_ret.sv
module sdram_rd_ret #(
  parameter int CL   = 3,
  parameter int BL   = 4,
  parameter int ID_W = 4,
  parameter int DQ_W = 16,
  localparam int RW  = $clog2(BL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic            valid_o,
  output logic [DQ_W-1:0] data_o,
  output logic [ID_W-1:0] id_o
);
  logic [CL-1:0]   sr_v;
  logic [ID_W-1:0] sr_id [CL];
  logic [RW-1:0]   rem_q;
  logic            tap_v;

  // latency line: stage CL-1 marks the cycle of the first word on dq_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_v <= '0;
      for (int k = 0; k < CL; k++) sr_id[k] <= '0;
    end else begin
      sr_v <= {sr_v[CL-2:0], issue_i};
      sr_id[0] <= id_i;
      for (int k = 1; k < CL; k++) sr_id[k] <= sr_id[k-1];
    end
  end

  assign tap_v = sr_v[CL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      id_o    <= '0;
      rem_q   <= '0;
    end else begin
      valid_o <= tap_v || (rem_q != '0);
      data_o  <= dq_i;
      if (tap_v) begin
        rem_q <= RW'(BL - 1);
        id_o  <= sr_id[CL-1];
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assert_burst_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_v |=> valid_o);
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int ID_W   = 4,
  parameter int DQ_W   = 16,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RRD  = 2,
  parameter int T_RC   = 9,
  parameter int CL     = 3,
  parameter int BL     = 4,
  parameter int AP_BIT = 10,
  localparam int BW    = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BW-1:0]    req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [ID_W-1:0]  req_id_i,
  output logic [1:0]       cmd_o,
  output logic [BW-1:0]    ba_o,
  output logic [ROW_W-1:0] addr_o,
  input  logic [DQ_W-1:0]  dq_i,
  output logic             rd_valid_o,
  output logic [DQ_W-1:0]  rd_data_o,
  output logic [ID_W-1:0]  rd_id_o
);
  localparam int RD_MIN  = (T_RAS - BL > T_RCD) ? T_RAS - BL : T_RCD;
  localparam int CNT_MAX = T_RC + T_RAS + T_RCD + T_RRD + T_RP + BL;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic             pend_v;
  logic [BW-1:0]    pend_bank;
  logic [COL_W-1:0] pend_col;
  logic [ID_W-1:0]  pend_id;
  logic [CW-1:0]    pend_age, bus_age;
  logic             act_ok, act_go, rd_go;
  cmd_e             cmd;

  assign rd_go       = pend_v && (pend_age >= CW'(RD_MIN)) && (bus_age >= CW'(BL));
  assign req_ready_o = act_ok && !pend_v;
  assign act_go      = req_valid_i && req_ready_o;

  sdram_act_gov #(
    .NB(NB), .T_RRD(T_RRD), .T_RC(T_RC), .T_RP(T_RP), .BL(BL), .CNT_MAX(CNT_MAX)
  ) u_gov (
    .clk_i, .rst_ni,
    .act_i(act_go), .rd_i(rd_go),
    .bank_i(req_bank_i), .rd_bank_i(pend_bank),
    .act_ok_o(act_ok)
  );

  // single slot: activated request waiting for its read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v    <= 1'b0;
      pend_bank <= '0;
      pend_col  <= '0;
      pend_id   <= '0;
      pend_age  <= CW'(CNT_MAX);
      bus_age   <= CW'(CNT_MAX);
    end else begin
      if (act_go) begin
        pend_v    <= 1'b1;
        pend_bank <= req_bank_i;
        pend_col  <= req_col_i;
        pend_id   <= req_id_i;
        pend_age  <= CW'(1);
      end else begin
        if (rd_go) pend_v <= 1'b0;
        if (pend_age != CW'(CNT_MAX)) pend_age <= pend_age + 1'b1;
      end
      if (rd_go)                         bus_age <= CW'(1);
      else if (bus_age != CW'(CNT_MAX))  bus_age <= bus_age + 1'b1;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (rd_go) begin
      cmd                 = CMD_RDA;
      ba_o                = pend_bank;
      addr_o[COL_W-1:0]   = pend_col;
      addr_o[AP_BIT]      = 1'b1;
    end else if (act_go) begin
      cmd    = CMD_ACT;
      ba_o   = req_bank_i;
      addr_o = req_row_i;
    end
  end
  assign cmd_o = cmd;

  sdram_rd_ret #(.CL(CL), .BL(BL), .ID_W(ID_W), .DQ_W(DQ_W)) u_ret (
    .clk_i, .rst_ni,
    .issue_i(rd_go), .id_i(pend_id), .dq_i,
    .valid_o(rd_valid_o), .data_o(rd_data_o), .id_o(rd_id_o)
  );

  assert_trcd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go |=> !rd_go);
  assert_bus_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> !rd_go);
  assert_slot_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go |=> pend_v);
  assert_nop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_v && !req_valid_i) |-> cmd_o == 2'd0);
endmodule

// File: tb/tb_sdram_rd_seq.sv
`timescale 1ns/1ps
module tb_sdram_rd_seq;
  localparam int NB = 4, ROW_W = 12, COL_W = 8, ID_W = 4, DQ_W = 16;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RRD = 2, T_RC = 9, CL = 3, BL = 4;
  localparam int RD_MIN = (T_RAS - BL > T_RCD) ? T_RAS - BL : T_RCD;
  localparam int NREQ = 48;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [1:0] req_bank_i = '0;
  logic [ROW_W-1:0] req_row_i = '0;
  logic [COL_W-1:0] req_col_i = '0;
  logic [ID_W-1:0] req_id_i = '0;
  logic [1:0] cmd_o, ba_o;
  logic [ROW_W-1:0] addr_o;
  logic [DQ_W-1:0] dq_i = '0, rd_data_o;
  logic rd_valid_o;
  logic [ID_W-1:0] rd_id_o;

  always #2.5 clk_i = ~clk_i;

  sdram_rd_seq dut (.*);

  int vectors = 0, fails = 0;
  bit finished = 0;

  // model state
  int head = 0, m_la1 = -1000, m_la2 = -1000, m_lrd = -1000, m_pend_t = 0;
  bit m_pend = 0;
  int m_bfree [NB];
  // observed-stream state
  int o_la1 = -1000, o_la2 = -1000, o_lrd = -1000, reads = 0, overlap = 0;
  int o_bfree [NB];
  int acc_q [$];
  bit exp_v [64];
  int exp_id [64];
  int exp_d [64];
  bit gap, mrd, mok, acc;
  int ecmd, idx, ri;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dqf(input int c);
    return ((c * 40503) ^ 23130) & 16'hFFFF;
  endfunction
  function automatic int q_bank(input int i);
    if (i < 12) return i % 4;
    if (i < 24) return 0;
    if (i < 36) return (i / 2) % 4;
    return (i * 3) % 4;
  endfunction
  function automatic int q_row(input int i); return (i * 37 + 5) % 4096; endfunction
  function automatic int q_col(input int i); return (i * 11 + 3) % 256; endfunction
  function automatic int q_id(input int i);  return i % 16; endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R9: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_bfree[b] = 0; o_bfree[b] = 0; end
    for (int k = 0; k < 64; k++) exp_v[k] = 0;
    repeat (4) begin
      @(negedge clk_i);
      chk("R9 reset cmd", int'(cmd_o), 0);
      chk("R9 reset rd_valid", int'(rd_valid_o), 0);
    end
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk_i);
      gap = (head >= 36) && (cyc % 3 == 0);
      ri = (head < NREQ) ? head : NREQ - 1;
      req_valid_i = (head < NREQ) && !gap;
      req_bank_i  = 2'(q_bank(ri));
      req_row_i   = ROW_W'(q_row(ri));
      req_col_i   = COL_W'(q_col(ri));
      req_id_i    = ID_W'(q_id(ri));
      dq_i        = DQ_W'(dqf(cyc));
      #1;
      // returned data (R7)
      idx = cyc % 64;
      chk("R7 rd_valid", int'(rd_valid_o), int'(exp_v[idx]));
      if (exp_v[idx] && rd_valid_o) begin
        chk("R7 rd_data", int'(rd_data_o), exp_d[idx]);
        chk("R7 rd_id", int'(rd_id_o), exp_id[idx]);
      end
      exp_v[idx] = 0;
      // model prediction
      mrd = m_pend && (cyc - m_pend_t >= RD_MIN) && (cyc - m_lrd >= BL);
      mok = !m_pend && (cyc - m_la1 >= T_RRD) && (cyc - m_la2 >= T_RC) &&
            (cyc >= m_bfree[q_bank(ri)]);
      chk("R1 ready", int'(req_ready_o), int'(mok));
      ecmd = mrd ? 2 : ((mok && req_valid_i) ? 1 : 0);
      chk(ecmd == 2 ? "R2 read cmd" : (ecmd == 1 ? "R1 act cmd" : "R9 nop"), int'(cmd_o), ecmd);
      if (mrd) begin
        m_pend = 0; m_lrd = cyc; m_bfree[acc_q.size() > 0 ? q_bank(acc_q[0]) : 0] = cyc + BL + T_RP;
      end else if (mok && req_valid_i) begin
        m_pend = 1; m_pend_t = cyc; m_la2 = m_la1; m_la1 = cyc;
      end
      // observed stream
      acc = req_valid_i && req_ready_o;
      if (cmd_o == 2'd1) begin
        chk("R3 act spacing", int'(cyc - o_la1 >= T_RRD), 1);
        chk("R4 act window", int'(cyc - o_la2 >= T_RC), 1);
        chk("R5 bank reuse", int'(cyc >= o_bfree[ba_o]), 1);
        chk("R1 act bank", int'(ba_o), int'(req_bank_i));
        chk("R1 act row", int'(addr_o), int'(req_row_i));
        chk("R1 act handshake", int'(acc), 1);
        if (rd_valid_o) overlap++;
        o_la2 = o_la1; o_la1 = cyc;
      end
      if (cmd_o == 2'd2) begin
        chk("R6 read spacing", int'(cyc - o_lrd >= BL), 1);
        chk("R8 read pending", int'(acc_q.size() > 0), 1);
        if (acc_q.size() > 0) begin
          chk("R8 read order bank", int'(ba_o), q_bank(acc_q[0]));
          chk("R2 read addr", int'(addr_o), q_col(acc_q[0]) | 1024);
          for (int j = 0; j < BL; j++) begin
            exp_v[(cyc + CL + 1 + j) % 64]  = 1;
            exp_id[(cyc + CL + 1 + j) % 64] = q_id(acc_q[0]);
            exp_d[(cyc + CL + 1 + j) % 64]  = dqf(cyc + CL + j);
          end
          void'(acc_q.pop_front());
        end
        o_bfree[ba_o] = cyc + BL + T_RP;
        o_lrd = cyc;
        reads++;
      end
      if (acc) begin
        acc_q.push_back(head);
        head++;
      end
      if (head == NREQ && !m_pend && acc_q.size() == 0 && cyc > o_lrd + CL + BL + 3) break;
    end
    chk("R8 all requests read", reads, NREQ);
    chk("R8 activate during burst", int'(overlap > 0), 1);
    finished = 1;
    summary();
    $finish;
  end
endmodule